// File: doc/BRIEF.md
# Grouped Interrupt Combiner

The combiner takes a wide set of level-sensitive interrupt sources and funnels them into a small number of upstream interrupt lines. Sources are arranged in groups of eight, and each group drives one combined line toward a higher-level interrupt controller. Each source has its own enable bit. A group line stays high for as long as any enabled source in that group is held high.

Software reaches the block through a simple word-wide register port. Enables are changed through two write-only strobes: a set register and a clear register, each acting only on the bits written as one. Because of this, masking or unmasking one source never needs a read-modify-write, even though four groups share each 32-bit word. The port also has a read-back view of the enable word and a masked status word. Software picks the source to service by taking the lowest set status bit in the group's byte.

Top module: `irq_combiner_top`

## Requirements
- R1: After reset every enable bit is 0, every group output is 0, and the enable view and the status word both read 0.
- R2: A write to offset 0x0 of word w sets the enable of every source in word w whose data bit is 1. Enables whose data bit is 0 keep their value.
- R3: A write to offset 0x4 of word w clears the enable of every source in word w whose data bit is 1. Enables whose data bit is 0 keep their value.
- R4: A read of offset 0x8 of word w returns the current 32-bit enable word w.
- R5: A read of offset 0xC of word w returns the status word. Bit b of this word is 1 exactly when source 32*w+b is high and its enable is set.
- R6: Group g occupies bits [8*(g mod 4)+7 : 8*(g mod 4)] of word g/4. Output bit g is the OR of that group's eight status bits.
- R7: Outputs are level-following and combinational from the sources and the enable state. An output stays asserted for as long as an enabled source is held high, and drops in the same cycle that the source falls.
- R8: Writes to offset 0x8 and offset 0xC change no enable.
- R9: Read data is registered and is valid one cycle after the read strobe. Reads of an unmapped offset or an out-of-range word return 0.

Address map: reg_addr[3:2] selects the register (0: set, 1: clear, 2: enable view, 3: status). reg_addr[AW-1:4] selects the word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_irq | input | NUM_SRC | Level-sensitive interrupt sources |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_addr | input | ADDR_W | Byte address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid one cycle after reg_rd |
| grp_irq | output | NUM_GRP | Combined output per group |

## Verification
A write to the enable registers takes effect at the next clock edge. The bench therefore checks enable-dependent results from the cycle after the write strobe. Group outputs have no register between the sources and the output, so the bench samples them in the same cycle it changes src_irq, after a short settling delay and before the next edge. Read data is checked one edge after reg_rd. All samples are taken on the falling clock edge.

// File: rtl/irq_combiner_pkg.sv
package irq_combiner_pkg;
    localparam int WORD_W    = 32;
    localparam int GRP_SIZE  = 8;
    localparam int GRP_PER_W = WORD_W / GRP_SIZE;

    typedef enum logic [1:0] {
        REG_EN_SET  = 2'd0,
        REG_EN_CLR  = 2'd1,
        REG_EN_VIEW = 2'd2,
        REG_STATUS  = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic [WORD_W-1:0] set_mask;
        logic [WORD_W-1:0] clr_mask;
    } en_update_t;

    function automatic logic [WORD_W-1:0] apply_update(
        input logic [WORD_W-1:0] cur,
        input en_update_t        upd
    );
        return (cur | upd.set_mask) & ~upd.clr_mask;
    endfunction
endpackage

// File: rtl/irq_enable_bank.sv
module irq_enable_bank
    import irq_combiner_pkg::*;
#(
    parameter int NUM_WORDS = 2
) (
    input  logic                              clk,
    input  logic                              rst,
    input  en_update_t [NUM_WORDS-1:0]        upd,
    output logic [NUM_WORDS-1:0][WORD_W-1:0]  en_q
);
    for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
        always_ff @(posedge clk) begin
            if (rst) en_q[w] <= '0;
            else     en_q[w] <= apply_update(en_q[w], upd[w]);
        end
    end
endmodule

// File: rtl/irq_group_or.sv
module irq_group_or
    import irq_combiner_pkg::*;
#(
    parameter int NUM_GRP = 8
) (
    input  logic [NUM_GRP*GRP_SIZE-1:0] status,
    output logic [NUM_GRP-1:0]          grp_irq
);
    for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
        assign grp_irq[g] = |status[g*GRP_SIZE +: GRP_SIZE];
    end
endmodule

// File: rtl/irq_reg_port.sv
module irq_reg_port
    import irq_combiner_pkg::*;
#(
    parameter int NUM_WORDS = 2,
    parameter int ADDR_W    = 8
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              reg_wr,
    input  logic                              reg_rd,
    input  logic [ADDR_W-1:0]                 reg_addr,
    input  logic [WORD_W-1:0]                 reg_wdata,
    input  logic [NUM_WORDS-1:0][WORD_W-1:0]  en_q,
    input  logic [NUM_WORDS-1:0][WORD_W-1:0]  status,
    output en_update_t [NUM_WORDS-1:0]        upd,
    output logic [WORD_W-1:0]                 reg_rdata
);
    localparam int WIDX_W = ADDR_W - 4;

    reg_sel_e            sel;
    logic [WIDX_W-1:0]   widx;
    logic [WORD_W-1:0]   rd_next;

    assign sel  = reg_sel_e'(reg_addr[3:2]);
    assign widx = reg_addr[ADDR_W-1:4];

    always_comb begin
        for (int w = 0; w < NUM_WORDS; w++) begin
            upd[w].set_mask = '0;
            upd[w].clr_mask = '0;
            if (reg_wr && (32'(widx) == w)) begin
                if (sel == REG_EN_SET) upd[w].set_mask = reg_wdata;
                if (sel == REG_EN_CLR) upd[w].clr_mask = reg_wdata;
            end
        end
    end

    always_comb begin
        rd_next = '0;
        for (int w = 0; w < NUM_WORDS; w++) begin
            if (32'(widx) == w) begin
                case (sel)
                    REG_EN_VIEW: rd_next = en_q[w];
                    REG_STATUS:  rd_next = status[w];
                    default:     rd_next = '0;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)         reg_rdata <= '0;
        else if (reg_rd) reg_rdata <= rd_next;
    end
endmodule

// File: rtl/irq_combiner_top.sv
module irq_combiner_top
    import irq_combiner_pkg::*;
#(
    parameter int NUM_GRP = 8,
    parameter int ADDR_W  = 8,
    localparam int NUM_SRC = NUM_GRP * GRP_SIZE
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] src_irq,
    input  logic               reg_wr,
    input  logic               reg_rd,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic [31:0]        reg_wdata,
    output logic [31:0]        reg_rdata,
    output logic [NUM_GRP-1:0] grp_irq
);
    localparam int NUM_WORDS = (NUM_GRP + GRP_PER_W - 1) / GRP_PER_W;
    localparam int PAD_W     = NUM_WORDS * WORD_W;

    en_update_t [NUM_WORDS-1:0]        upd;
    logic [NUM_WORDS-1:0][WORD_W-1:0]  en_q;
    logic [NUM_WORDS-1:0][WORD_W-1:0]  status;
    logic [PAD_W-1:0]                  src_pad;

    assign src_pad = PAD_W'(src_irq);
    assign status  = en_q & src_pad;

    irq_enable_bank #(.NUM_WORDS(NUM_WORDS)) u_bank (
        .clk (clk),
        .rst (rst),
        .upd (upd),
        .en_q(en_q)
    );

    irq_reg_port #(.NUM_WORDS(NUM_WORDS), .ADDR_W(ADDR_W)) u_port (
        .clk      (clk),
        .rst      (rst),
        .reg_wr   (reg_wr),
        .reg_rd   (reg_rd),
        .reg_addr (reg_addr),
        .reg_wdata(reg_wdata),
        .en_q     (en_q),
        .status   (status),
        .upd      (upd),
        .reg_rdata(reg_rdata)
    );

    irq_group_or #(.NUM_GRP(NUM_GRP)) u_or (
        .status (status[NUM_SRC-1:0]),
        .grp_irq(grp_irq)
    );
endmodule

// File: rtl/irq_combiner_chk.sv
module irq_combiner_chk #(
    parameter int NUM_GRP = 8,
    parameter int ADDR_W  = 8
) (
    input logic               clk,
    input logic               rst,
    input logic               reg_wr,
    input logic               reg_rd,
    input logic [ADDR_W-1:0]  reg_addr,
    input logic [31:0]        reg_wdata,
    input logic [31:0]        reg_rdata,
    input logic [NUM_GRP-1:0] grp_irq,
    input logic [NUM_GRP*8-1:0] src_irq
);
    // R1
    reset_quiet_chk: assert property (@(posedge clk) rst |=> (grp_irq == '0 && reg_rdata == '0));
    // R7
    no_src_no_out_chk: assert property (@(posedge clk) disable iff (rst) (src_irq == '0) |-> (grp_irq == '0));
    // R9
    rdata_hold_chk: assert property (@(posedge clk) disable iff (rst) !reg_rd |=> $stable(reg_rdata));
    // R8
    view_write_keeps_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr[3] && $stable(src_irq)) |=> (grp_irq == $past(grp_irq)) || !$stable(src_irq));
    // R6
    group_needs_src_chk: assert property (@(posedge clk) disable iff (rst)
        $countones(grp_irq) <= $countones(src_irq));
endmodule

bind irq_combiner_top irq_combiner_chk #(.NUM_GRP(NUM_GRP), .ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .grp_irq(grp_irq), .src_irq(src_irq)
);

// File: tb/irq_combiner_tb.sv
module irq_combiner_top_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NUM_GRP = 8;
    localparam int NSRC = NUM_GRP * 8;
    localparam int NW = NUM_GRP / 4;

    logic clk = 0, rst = 1;
    logic [NSRC-1:0] src_irq = '0;
    logic reg_wr = 0, reg_rd = 0;
    logic [7:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0, reg_rdata;
    logic [NUM_GRP-1:0] grp_irq;

    int checks = 0, errors = 0;
    logic [NSRC-1:0] model_en = '0;

    irq_combiner_top #(.NUM_GRP(NUM_GRP), .ADDR_W(8)) dut_i (
        .clk(clk), .rst(rst), .src_irq(src_irq), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .grp_irq(grp_irq));

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [NUM_GRP-1:0] exp_grp(input logic [NSRC-1:0] en, input logic [NSRC-1:0] s);
        logic [NUM_GRP-1:0] r;
        for (int g = 0; g < NUM_GRP; g++) r[g] = |(en[g*8 +: 8] & s[g*8 +: 8]);
        return r;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input int w, input int sel, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1; reg_addr = 8'(w*16 + sel*4); reg_wdata = d;
        @(negedge clk);
        reg_wr = 0;
        if (sel == 0) model_en[w*32 +: 32] = model_en[w*32 +: 32] | d;
        if (sel == 1) model_en[w*32 +: 32] = model_en[w*32 +: 32] & ~d;
    endtask

    task automatic rd(input int w, input int sel, output logic [31:0] d);
        @(negedge clk);
        reg_rd = 1; reg_addr = 8'(w*16 + sel*4);
        @(negedge clk);
        reg_rd = 0;
        d = reg_rdata;
    endtask

    task automatic check_all(input string req);
        logic [31:0] d;
        #1;
        check({req, " grp"}, 32'(grp_irq), 32'(exp_grp(model_en, src_irq)));
        for (int w = 0; w < NW; w++) begin
            rd(w, 2, d); check({req, " view"}, d, model_en[w*32 +: 32]);
            rd(w, 3, d); check({req, " status"}, d, model_en[w*32 +: 32] & src_irq[w*32 +: 32]);
        end
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 100000);
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] d;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst = 0;
        // R1 reset state
        check("R1 grp", 32'(grp_irq), 32'h0);
        src_irq = '1; #1;
        check("R1 grp all src", 32'(grp_irq), 32'h0);
        check_all("R1");
        // R2 set acts on ones only
        wr(0, 0, 32'h0000_0100);
        wr(0, 0, 32'h0000_0001);
        check_all("R2");
        // R6 group mapping: enable one bit in top byte of word 1 -> group 7
        src_irq = '0; wr(1, 0, 32'h8000_0000);
        src_irq[63] = 1; #1;
        check("R6 group7", 32'(grp_irq), 32'h80);
        // R7 drop same cycle
        src_irq[63] = 0; #1;
        check("R7 fall", 32'(grp_irq), 32'h0);
        // R3 clear acts on ones only
        wr(0, 1, 32'h0000_0001);
        src_irq = '1;
        check_all("R3");
        // R8 writes to view/status ignored
        wr(0, 2, 32'hFFFF_FFFF); wr(0, 3, 32'hFFFF_FFFF);
        wr(1, 2, 32'hFFFF_FFFF); wr(1, 3, 32'h0000_0000);
        check_all("R8");
        // R9 out of range word reads zero
        rd(3, 2, d); check("R9 oob view", d, 32'h0);
        rd(0, 0, d); check("R9 set offset", d, 32'h0);
        // R4 R5 random
        for (int i = 0; i < 40; i++) begin
            wr($urandom % NW, $urandom % 2, $urandom);
            src_irq = {$urandom, $urandom};
            check_all("R4 R5 R6 R7");
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule